// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, A and B, and moves a word from one to the other in either direction. Each direction owns a storage register. For the path being driven, a select line picks either the word arriving live from the far bus or the word held in that direction's register. The live path is combinational. The stored path returns a word captured on an earlier cycle.

An active-low enable and a direction input decide which bus, if any, is driven. While the enable is high, neither bus is driven. Both registers can still capture in that state, so the block can sample one or both buses while it drives nothing. Each pad is split into an input vector, an output vector and an output-enable vector, so a pad ring outside the block can build the three-state pins. Each register has its own capture strobe and captures on the rising edge of `clk`.

Top module: `regbus_xcvr`

## Requirements
- R1: A clock edge with `rst_n` low clears both storage registers to zero.
- R2: A rising edge of `clk` with `rst_n` high and `cap_ab` high loads `a_in` into the A-to-B register.
- R3: A rising edge of `clk` with `rst_n` high and `cap_ba` high loads `b_in` into the B-to-A register.
- R4: While `oe_n` is 1, `a_oe`, `b_oe`, `a_out` and `b_out` are all zero.
- R5: While `oe_n` is 0 and `dir` is 1, every bit of `b_oe` is 1 and `a_oe` is zero. `a_out` is zero.
- R6: While `oe_n` is 0 and `dir` is 0, every bit of `a_oe` is 1 and `b_oe` is zero. `b_out` is zero.
- R7: While B is driven, `b_out` equals the current `a_in` when `sel_ab` is 0, and equals the A-to-B register when `sel_ab` is 1.
- R8: While A is driven, `a_out` equals the current `b_in` when `sel_ba` is 0, and equals the B-to-A register when `sel_ba` is 1.
- R9: Capture into either register works the same way while `oe_n` is 1.
- R10: Both registers can capture on the same edge, each taking its own bus input.
- R11: `a_oe` and `b_oe` are never both nonzero.
- R12: On an edge with its capture strobe low, a register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both storage registers |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| sel_ab | input | 1 | Source for B: 0 live, 1 stored |
| sel_ba | input | 1 | Source for A: 0 live, 1 stored |
| cap_ab | input | 1 | Load the A-to-B register from `a_in` |
| cap_ba | input | 1 | Load the B-to-A register from `b_in` |
| a_in | input | DATA_W | Word read from bus A |
| a_out | output | DATA_W | Word to drive onto bus A |
| a_oe | output | DATA_W | Per-bit drive enable for bus A |
| b_in | input | DATA_W | Word read from bus B |
| b_out | output | DATA_W | Word to drive onto bus B |
| b_oe | output | DATA_W | Per-bit drive enable for bus B |

## Verification
Directed phases cover the following cases:
- Isolated captures into each register alone and into both together, which separates the two strobes and shows that storage does not depend on the enable.
- Live versus stored selection in each direction, with different words on the two buses, which shows which source feeds each output.
- Capture of the receiving bus while the other bus is driven live.

A long random phase then changes every control input and both bus words on every cycle. The bench's model is compared with all four output vectors on each clock, which catches swapped paths, stale registers and overlapping drive enables.

// File: rtl/xcvr_pkg.sv
// Package: types shared by the bus transceiver modules.
// Assumes: nothing beyond standard SystemVerilog.
package xcvr_pkg;

    // Drive decision: which bus the block may drive this cycle.
    typedef struct packed {
        logic a_en;
        logic b_en;
    } drive_t;

    // Direction encoding on the dir pin.
    localparam logic DIR_TO_B = 1'b1;
    localparam logic DIR_TO_A = 1'b0;

endpackage

// File: rtl/xcvr_store.sv
// Module: one storage register for one direction of the transceiver.
// Loads d on a clock edge while cap is high and holds otherwise.
// Assumes: rst_n is synchronous and active low.
module xcvr_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Register update: clear on reset, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (cap)
            q <= d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> q == '0);

    // R2 R3 R9 R10
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cap)) |-> q == $past(d));

    // R12
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cap)) |-> $stable(q));

endmodule

// File: rtl/xcvr_path_mux.sv
// Module: source selection and gating for one driven path.
// Picks the live word or the stored word, and forces zero when the path is not driven.
// Assumes: en comes from the drive control and is one bit.
module xcvr_path_mux #(
    parameter int DATA_W = 8
) (
    input  logic              en,
    input  logic              sel,
    input  logic [DATA_W-1:0] live,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] y
);

    // Output word: stored when sel is 1, live when sel is 0, zero when not driven.
    always_comb begin
        if (!en)
            y = '0;
        else if (sel)
            y = stored;
        else
            y = live;
    end

endmodule

// File: rtl/xcvr_drive_ctl.sv
// Module: drive control for both buses.
// Decodes the active-low enable and the direction into per-bus drive flags.
// Assumes: dir is 1 to drive B and 0 to drive A.
module xcvr_drive_ctl
    import xcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    output drive_t drv
);

    // Drive decode: at most one bus, and only while the enable is low.
    always_comb begin
        drv.b_en = !oe_n && (dir == DIR_TO_B);
        drv.a_en = !oe_n && (dir == DIR_TO_A);
    end

endmodule

// File: rtl/regbus_xcvr.sv
// Module: registered bidirectional bus transceiver (top).
// Joins buses A and B. Each direction has a storage register and a live/stored selector.
// Assumes: the pads are built outside the block from the in/out/oe vectors,
// and reset is synchronous and active low.
module regbus_xcvr
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              dir,
    input  logic              sel_ab,
    input  logic              sel_ba,
    input  logic              cap_ab,
    input  logic              cap_ba,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] a_oe,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic [DATA_W-1:0] b_oe
);

    logic [DATA_W-1:0] reg_ab;
    logic [DATA_W-1:0] reg_ba;
    drive_t            drv;

    xcvr_store #(.DATA_W(DATA_W)) u_store_ab (
        .clk(clk), .rst_n(rst_n), .cap(cap_ab), .d(a_in), .q(reg_ab)
    );

    xcvr_store #(.DATA_W(DATA_W)) u_store_ba (
        .clk(clk), .rst_n(rst_n), .cap(cap_ba), .d(b_in), .q(reg_ba)
    );

    xcvr_drive_ctl u_drive (
        .oe_n(oe_n), .dir(dir), .drv(drv)
    );

    xcvr_path_mux #(.DATA_W(DATA_W)) u_mux_to_b (
        .en(drv.b_en), .sel(sel_ab), .live(a_in), .stored(reg_ab), .y(b_out)
    );

    xcvr_path_mux #(.DATA_W(DATA_W)) u_mux_to_a (
        .en(drv.a_en), .sel(sel_ba), .live(b_in), .stored(reg_ba), .y(a_out)
    );

    // Enable fan-out: one enable bit per pad.
    for (genvar i = 0; i < DATA_W; i++) begin : g_oe
        assign a_oe[i] = drv.a_en;
        assign b_oe[i] = drv.b_en;
    end

    // R11
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|a_oe) && (|b_oe)));

    // R4
    isolation_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

    // R5
    drive_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir) |-> (&b_oe && a_oe == '0 && a_out == '0));

    // R6
    drive_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir) |-> (&a_oe && b_oe == '0 && b_out == '0));

    // R7
    live_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir && !sel_ab) |-> b_out == a_in);

    // R8
    live_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir && !sel_ba) |-> a_out == b_in);

endmodule

// File: tb/regbus_xcvr_tb.sv
// Bench: behavioural model, compared with the outputs on every clock.
module regbus_xcvr_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba;
    logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int errors = 0;
    int m_ab   = 0;
    int m_ba   = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    regbus_xcvr #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, compare the outputs before the edge, then advance the model.
    task automatic step(input string tag, input bit rn, input bit oen, input bit d,
                        input bit sab, input bit sba, input bit cab, input bit cba,
                        input int av, input int bv);
        int ea_out, eb_out, ea_oe, eb_oe;
        @(negedge clk);
        rst_n = rn; oe_n = oen; dir = d; sel_ab = sab; sel_ba = sba;
        cap_ab = cab; cap_ba = cba; a_in = W'(av); b_in = W'(bv);
        #1;
        eb_oe  = (!oen && d)  ? 255 : 0;
        ea_oe  = (!oen && !d) ? 255 : 0;
        eb_out = (eb_oe != 0) ? (sab ? m_ab : (av & 255)) : 0;
        ea_out = (ea_oe != 0) ? (sba ? m_ba : (bv & 255)) : 0;
        chk(tag, int'(a_out), ea_out, "a_out");
        chk(tag, int'(b_out), eb_out, "b_out");
        chk(tag, int'(a_oe),  ea_oe,  "a_oe");
        chk(tag, int'(b_oe),  eb_oe,  "b_oe");
        chk("R11", int'((|a_oe) && (|b_oe)), 0, "both enables");
        @(posedge clk);
        if (!rn) begin
            m_ab = 0; m_ba = 0;
        end else begin
            if (cab) m_ab = av & 255;
            if (cba) m_ba = bv & 255;
        end
    endtask

    initial begin
        rst_n = 0; oe_n = 1; dir = 0; sel_ab = 0; sel_ba = 0;
        cap_ab = 0; cap_ba = 0; a_in = '0; b_in = '0;
        // Hold reset with nonzero words and strobes high, so the reset must win.
        step("R1", 0, 1, 0, 0, 0, 1, 1, 8'h5A, 8'hA5);
        step("R1", 0, 1, 0, 0, 0, 1, 1, 8'h5A, 8'hA5);
        // The registers read back as zero through the stored paths.
        step("R1", 1, 0, 1, 1, 0, 0, 0, 8'h77, 8'h00);
        step("R1", 1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h66);
        // Isolation: capture into each register alone.
        step("R9", 1, 1, 0, 0, 0, 1, 0, 8'h3C, 8'hFF);
        step("R2", 1, 0, 1, 1, 0, 0, 0, 8'h00, 8'h00);
        step("R9", 1, 1, 1, 0, 0, 0, 1, 8'hFF, 8'hC3);
        step("R3", 1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00);
        // Isolation: capture into both registers on the same edge.
        step("R10", 1, 1, 0, 1, 1, 1, 1, 8'h81, 8'h18);
        step("R10", 1, 0, 1, 1, 0, 0, 0, 8'h00, 8'h00);
        step("R10", 1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00);
        // Hold: strobes low with new words on the buses.
        step("R12", 1, 1, 0, 0, 0, 0, 0, 8'hEE, 8'hDD);
        step("R12", 1, 0, 1, 1, 0, 0, 0, 8'h11, 8'h22);
        step("R12", 1, 0, 0, 0, 1, 0, 0, 8'h33, 8'h44);
        // Live versus stored, in each direction.
        step("R7", 1, 0, 1, 0, 0, 0, 0, 8'h9A, 8'h00);
        step("R5", 1, 0, 1, 1, 1, 0, 0, 8'h9A, 8'h55);
        step("R8", 1, 0, 0, 0, 0, 0, 0, 8'h00, 8'hB7);
        step("R6", 1, 0, 0, 1, 1, 0, 0, 8'h44, 8'hB7);
        // Capture the receiving bus while the other bus is driven.
        step("R2", 1, 0, 1, 0, 0, 1, 0, 8'h4E, 8'h00);
        step("R7", 1, 0, 1, 1, 0, 0, 0, 8'h00, 8'h00);
        step("R3", 1, 0, 0, 0, 0, 0, 1, 8'h00, 8'hE4);
        step("R8", 1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00);
        step("R4", 1, 1, 1, 1, 1, 0, 0, 8'hFF, 8'hFF);
        // Random phase: every control and both words change each cycle.
        for (int n = 0; n < 400; n++) begin
            bit  oen = 1'($urandom);
            bit  d   = 1'($urandom);
            bit  sab = 1'($urandom);
            bit  sba = 1'($urandom);
            string tg;
            if (oen)       tg = "R4";
            else if (d)    tg = sab ? "R7" : "R5";
            else           tg = sba ? "R8" : "R6";
            step(tg, ($urandom % 32) != 0, oen, d, sab, sba, 1'($urandom), 1'($urandom),
                 int'($urandom % 256), int'($urandom % 256));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule